// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter for use as an operating-system time base. Software programs a reload value and turns the counter on. The counter then decrements once per tick of a chosen clock-enable source. Each time the count expires, the counter reloads, raises a sticky wrap flag and, if enabled, sends a one-cycle request to an exception controller. That controller is outside the block.

The block does no clock generation. Two single-cycle tick-enable strobes arrive from outside, one derived from the core clock and one from a reference clock, and a control bit selects which of them drives the count. Software reaches four word registers through a simple 32-bit read/write port. Register reads are combinational from the current state. A read of the control register clears the wrap flag at the clock edge that completes the read.

Top module: `tick_timer`

## Requirements
- R1: Control register at byte offset 0x10. Bit 0 enables counting, bit 1 enables the exception request, bit 2 selects the tick source and bit 16 is the wrap flag. A write changes only bits 2:0, and all other bits read as zero.
- R2: A read of the control register returns its current value. The wrap flag is then cleared, unless an expiry sets it in the same cycle.
- R3: On expiry the wrap flag is set. When bit 1 is set, `tick_req_o` goes high for exactly one cycle, in the cycle after the expiring tick.
- R4: Setting bit 0 when it was clear loads the count from the reload value. Each expiry takes reload+1 selected ticks, counting from enable and between successive expiries.
- R5: With bit 2 clear, `core_tick_i` drives the count. With bit 2 set, `ref_tick_i` drives it. Strobes on the unselected input have no effect.
- R6: A write of any value to the current-value register (offset 0x18) restarts the count from the reload value and clears the wrap flag.
- R7: The current-value register reads zero while bit 0 is clear. Otherwise it reads the remaining count, which is reload minus the number of selected ticks since the load.
- R8: The calibration register (offset 0x1C) always reads the decimal constant 10000.
- R9: When the count expires with a reload value of zero, counting stops and bit 0 clears.
- R10: The reload register (offset 0x14) and the current-value register hold 24 bits. Bits 31:24 read as zero.
- R11: Reset clears the control, reload and current-value registers. Offsets not listed above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| core_tick_i | input | 1 | Core-clock tick enable strobe |
| ref_tick_i | input | 1 | Reference tick enable strobe |
| tick_req_o | output | 1 | One-cycle exception request on expiry |

## Verification
Some properties are checked on every cycle, whatever traffic the bench produces:
- the wrap flag is set after every expiry;
- a read of the control register clears the flag;
- an expiry with a reload value of zero drops the enable bit;
- the count holds while counting is off;
- every request is accompanied by the flag.

Other properties can only be shown by the bench's arithmetic sweeps over reload values and both tick sources:
- the exact period of reload+1 ticks;
- the immunity to strobes on the unselected input;
- the remaining-count readback;
- the restart on a write to the current-value register;
- the register masking.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CUR    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CAL    = 8'h1C;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_INTEN = 1;
  localparam int unsigned BIT_SRC   = 2;
  localparam int unsigned BIT_FLAG  = 16;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_reload;
    logic wr_cur;
    logic rd_ctrl;
  } bus_op_t;
endpackage

// File: rtl/tick_timer_clksel.sv
module tick_timer_clksel (
  input  logic core_tick_i,
  input  logic ref_tick_i,
  input  logic src_i,
  output logic tick_o
);
  assign tick_o = src_i ? ref_tick_i : core_tick_i;
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_op_t          op_i,
  input  logic [2:0]       wctrl_i,
  input  logic [CNT_W-1:0] wreload_i,
  input  logic             expire_i,
  output logic             en_o,
  output logic             inten_o,
  output logic             src_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o,
  output logic             tick_req_o
);
  logic en_q, inten_q, src_q, flag_q, req_q;
  logic [CNT_W-1:0] reload_q;
  logic reload_zero;

  assign reload_zero = (reload_q == '0);
  assign start_o     = op_i.wr_ctrl & wctrl_i[0] & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      inten_q  <= 1'b0;
      src_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (op_i.wr_ctrl) begin
        en_q    <= wctrl_i[0];
        inten_q <= wctrl_i[1];
        src_q   <= wctrl_i[2];
      end else if (expire_i && reload_zero) begin
        en_q <= 1'b0;  // one-shot stop
      end
      if (op_i.wr_reload) reload_q <= wreload_i;
    end
  end

  // flag: restart clears, expiry sets, control read clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_q <= 1'b0;
    else if (op_i.wr_cur)   flag_q <= 1'b0;
    else if (expire_i)      flag_q <= 1'b1;
    else if (op_i.rd_ctrl)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= expire_i & inten_q;
  end

  assign en_o       = en_q;
  assign inten_o    = inten_q;
  assign src_o      = src_q;
  assign flag_o     = flag_q;
  assign reload_o   = reload_q;
  assign tick_req_o = req_q;

  AST_FLAG_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q); // R3
  AST_REQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> flag_q); // R3
  AST_RD_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.rd_ctrl && !expire_i && !op_i.wr_cur) |=> !flag_q); // R2
  AST_ZERO_RELOAD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && reload_zero && !op_i.wr_ctrl) |=> !en_q); // R9
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;

  // expiry is the tick taken while already at zero: reload+1 ticks per period
  assign expire_o = en_i & tick_i & ~load_i & (cur_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cur_q <= '0;
    else if (load_i)          cur_q <= reload_i;
    else if (expire_o)        cur_q <= reload_i;
    else if (en_i && tick_i)  cur_q <= cur_q - 1'b1;
  end

  assign cur_o = cur_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cur_q)); // R4
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              core_tick_i,
  input  logic              ref_tick_i,
  output logic              tick_req_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  bus_op_t          op;
  logic             en, inten, src, flag, start, tick, expire;
  logic [CNT_W-1:0] reload, cur;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  always_comb begin
    op.wr_ctrl   = req_i &  we_i & (addr_i == OFS_CTRL);
    op.wr_reload = req_i &  we_i & (addr_i == OFS_RELOAD);
    op.wr_cur    = req_i &  we_i & (addr_i == OFS_CUR);
    op.rd_ctrl   = req_i & ~we_i & (addr_i == OFS_CTRL);
  end

  tick_timer_clksel u_clksel (
    .core_tick_i (core_tick_i),
    .ref_tick_i  (ref_tick_i),
    .src_i       (src),
    .tick_o      (tick)
  );

  tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .wctrl_i    (wdata_i[2:0]),
    .wreload_i  (wdata_i[CNT_W-1:0]),
    .expire_i   (expire),
    .en_o       (en),
    .inten_o    (inten),
    .src_o      (src),
    .flag_o     (flag),
    .reload_o   (reload),
    .start_o    (start),
    .tick_req_o (tick_req_o)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .tick_i   (tick),
    .load_i   (start | op.wr_cur),
    .reload_i (reload),
    .cur_o    (cur),
    .expire_o (expire)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_EN]    = en;
        rdata_o[BIT_INTEN] = inten;
        rdata_o[BIT_SRC]   = src;
        rdata_o[BIT_FLAG]  = flag;
      end
      OFS_RELOAD: rdata_o = {{PAD_W{1'b0}}, reload};
      OFS_CUR:    rdata_o = en ? {{PAD_W{1'b0}}, cur} : '0;
      OFS_CAL:    rdata_o = DATA_W'(CAL_VALUE);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        core_tick = 1'b0, ref_tick = 1'b0;
  logic        tick_req;
  logic        src_sel = 1'b0;
  logic        done = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .core_tick_i(core_tick),
    .ref_tick_i(ref_tick), .tick_req_o(tick_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  // one selected tick, then one noise strobe on the other input
  task automatic do_tick(output logic irq);
    @(negedge clk);
    core_tick = !src_sel; ref_tick = src_sel;
    @(negedge clk);
    irq = tick_req;
    core_tick = src_sel; ref_tick = !src_sel;
    @(negedge clk);
    core_tick = 0; ref_tick = 0;
    if (irq) check("R3 request width", {31'b0, tick_req}, 32'h0);
  endtask

  task automatic run_period(int r, logic s);
    logic irq;
    logic exp;
    logic [31:0] d;
    src_sel = s;
    bus_wr(8'h10, 32'h0);
    bus_wr(8'h14, r);
    bus_wr(8'h10, {29'b0, s, 2'b11});
    for (int i = 1; i <= 3 * (r + 1) + 1; i++) begin
      do_tick(irq);
      exp = (r == 0) ? (i == 1) : ((i % (r + 1)) == 0);
      check($sformatf("R4 R5 period r=%0d src=%0d tick=%0d", r, s, i), {31'b0, irq}, {31'b0, exp});
    end
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic irq;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R11 reset state, R8 calibration
    bus_rd(8'h10, d); check("R11 ctrl reset", d, 32'h0);
    bus_rd(8'h14, d); check("R11 reload reset", d, 32'h0);
    bus_rd(8'h18, d); check("R11 cur reset", d, 32'h0);
    bus_rd(8'h1C, d); check("R8 calibration", d, 32'd10000);
    bus_rd(8'h20, d); check("R11 unmapped", d, 32'h0);

    // R1 write masking
    bus_wr(8'h10, 32'hFFFF_FFF8);
    bus_rd(8'h10, d); check("R1 upper bits ignored", d, 32'h0);
    bus_wr(8'h10, 32'h6);
    bus_rd(8'h10, d); check("R1 ctrl readback", d, 32'h6);
    bus_wr(8'h10, 32'h0);

    // R10 widths
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h14, d); check("R10 reload width", d, 32'h00FF_FFFF);
    bus_wr(8'h10, 32'h1);
    bus_rd(8'h18, d); check("R10 R4 cur loaded on enable", d, 32'h00FF_FFFF);
    bus_wr(8'h10, 32'h0);

    // R4 R5 R3 sweep over reload and source
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 6; r++)
        run_period(r, s[0]);

    // R2 R3 flag without request
    src_sel = 0;
    bus_wr(8'h14, 32'd2);
    bus_wr(8'h10, 32'h1);
    for (int i = 0; i < 3; i++) begin
      do_tick(irq);
      check("R3 no request when disabled", {31'b0, irq}, 32'h0);
    end
    bus_rd(8'h10, d); check("R2 R3 flag set", d, 32'h0001_0001);
    bus_rd(8'h10, d); check("R2 flag cleared by read", d, 32'h0000_0001);

    // R7 remaining count and disabled read
    bus_wr(8'h10, 32'h0);
    bus_wr(8'h14, 32'd10);
    bus_wr(8'h10, 32'h1);
    for (int i = 0; i < 3; i++) do_tick(irq);
    bus_rd(8'h18, d); check("R7 remaining count", d, 32'd7);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h18, d); check("R7 zero while disabled", d, 32'h0);
    bus_wr(8'h10, 32'h1);
    do_tick(irq);
    bus_rd(8'h18, d); check("R4 reenable reloads", d, 32'd9);
    bus_wr(8'h10, 32'h0);

    // R6 restart on current-value write
    bus_wr(8'h14, 32'd4);
    bus_wr(8'h10, 32'h3);
    for (int i = 1; i <= 5; i++) begin
      do_tick(irq);
      check("R6 setup expiry", {31'b0, irq}, {31'b0, i == 5});
    end
    for (int i = 0; i < 3; i++) do_tick(irq);
    bus_rd(8'h18, d); check("R7 count after wrap", d, 32'd1);
    bus_wr(8'h18, 32'h0000_0ABC);
    bus_rd(8'h18, d); check("R6 restarted from reload", d, 32'd4);
    bus_rd(8'h10, d); check("R6 flag cleared by restart", d, 32'h3);
    for (int i = 1; i <= 5; i++) begin
      do_tick(irq);
      check("R6 full period after restart", {31'b0, irq}, {31'b0, i == 5});
    end
    bus_wr(8'h10, 32'h0);

    // R9 one-shot stop with zero reload
    bus_rd(8'h10, d);
    bus_wr(8'h14, 32'd0);
    bus_wr(8'h10, 32'h3);
    do_tick(irq);
    check("R9 expiry with zero reload", {31'b0, irq}, 32'h1);
    bus_rd(8'h10, d); check("R9 enable cleared", d, 32'h0001_0002);
    do_tick(irq);
    check("R9 stays stopped", {31'b0, irq}, 32'h0);
    bus_rd(8'h18, d); check("R7 R9 cur zero after stop", d, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule